// File: doc/BRIEF.md
# Complementary PWM Deadband Generator

This block turns one raw PWM waveform into a pair of complementary drive outputs, even and odd, for a half-bridge style channel pair. In complementary mode the output that is switching off falls as soon as the raw level changes. The output that is switching on waits out a programmable dead interval, so the two outputs are never active at the same moment. In independent mode the raw level reaches the outputs with no delay.

The dead interval comes from a 12-bit value held in a byte-addressed register and from a prescaler setting P. For P of 0 or 1 the interval is the programmed count. For larger P it is P times the count, less one clock. A protect input locks the register until the next reset.

The block is built as a parameterised library cell. The value width, the prescaler width and the reset value are parameters. The byte lanes of the register are produced by a generate loop.

Top module: `pwm_deadband`

## Requirements
- R1: After reset the deadtime value is 0x0FFF: a read at address 0 gives 0xFF and a read at address 1 gives 0x0F. The lock is clear.
- R2: A write at address 0 loads value bits 7:0 from wr_data[7:0]. A write at address 1 loads value bits 11:8 from wr_data[3:0]. The other byte is left unchanged.
- R3: Bits 7:4 of the address-1 byte always read as zero, and the data written to them has no effect.
- R4: Once prot_set is high at a clock edge, every later write leaves the value unchanged, and the lock stays set until reset even after prot_set falls. A write at that same edge still takes effect.
- R5: The effective deadtime D is the programmed value N when the prescaler P is 0 or 1, and P*N-1 when P is 2 or more. It is 0 when N is 0.
- R6: In complementary mode, a rising raw level drives odd low within the same cycle. Even goes high at the D-th clock edge after the edge that first samples the new level, and at that edge itself when D is 0.
- R7: In complementary mode, a falling raw level drives even low within the same cycle. Odd goes high with the same D-edge timing as in R6.
- R8: In complementary mode, even and odd are never high together.
- R9: If the raw level changes again before the pending output has turned on, that output never rises, and the count restarts in full from the new edge.
- R10: With comp_mode low, even follows pwm_raw and odd follows its inverse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 1 | Byte lane selected for the write (0 low, 1 high) |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 1 | Byte lane selected for the read |
| rd_data | output | 8 | Read data byte, zero-padded |
| prot_set | input | 1 | Sets the sticky write lock |
| presc | input | 3 | Prescaler value P |
| comp_mode | input | 1 | 1 gives complementary mode, 0 gives independent pass-through |
| pwm_raw | input | 1 | Raw PWM level (high means even active) |
| out_even | output | 1 | Even output of the pair |
| out_odd | output | 1 | Odd output of the pair |

## Verification
The bench builds the block with its default parameters: a 12-bit value split over two byte lanes, and a 3-bit prescaler covering P from 0 to 7. With these widths the bench can reach the P=0 and P=1 no-subtract cases, the zero-value case, the largest prescaler, and the reserved upper nibble of the high byte. The 0x0FFF reset value is checked by readback, which keeps the run short, while small programmed values carry the timing checks on both output edges.

// File: rtl/pwm_deadband_pkg.sv
package pwm_deadband_pkg;
   // byte lane width of the register window
   localparam int LANE_W = 8;

   function automatic int lanes_for(input int bits);
      return (bits + LANE_W - 1) / LANE_W;
   endfunction

   function automatic int addr_bits_for(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction
endpackage

// File: rtl/pwm_dt_regfile.sv
module pwm_dt_regfile
   import pwm_deadband_pkg::*;
#(
   parameter int              DT_W     = 12,
   parameter logic [DT_W-1:0] DT_RESET = '1,
   parameter int              NLANES   = lanes_for(DT_W),
   parameter int              ADDR_W   = addr_bits_for(NLANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              prot_set,
   output logic [DT_W-1:0]   dt_value,
   output logic              locked
);
   localparam int PAD_W = (1 << ADDR_W) * LANE_W;

   logic [DT_W-1:0]  dt_q, dt_d;
   logic             lock_q;
   logic [PAD_W-1:0] rd_pad;

   generate
      for (genvar l = 0; l < NLANES; l++) begin : g_lane
         localparam int LO = l * LANE_W;
         localparam int W  = (DT_W - LO > LANE_W) ? LANE_W : DT_W - LO;
         logic lane_we;
         assign lane_we = wr_en && !lock_q && (wr_addr == ADDR_W'(l));
         assign dt_d[LO +: W] = lane_we ? wr_data[W-1:0] : dt_q[LO +: W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dt_q   <= DT_RESET;
         lock_q <= 1'b0;
      end else begin
         dt_q   <= dt_d;
         lock_q <= lock_q | prot_set;
      end
   end

   always_comb begin
      rd_pad = '0;
      rd_pad[DT_W-1:0] = dt_q;
   end

   assign rd_data  = rd_pad[rd_addr * LANE_W +: LANE_W];
   assign dt_value = dt_q;
   assign locked   = lock_q;

   AST_LOCK_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(dt_q)); // R4
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R4
endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer #(
   parameter int DT_W    = 12,
   parameter int PRESC_W = 3,
   parameter int CNT_W   = DT_W + PRESC_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               raw,
   input  logic [DT_W-1:0]    dt_value,
   input  logic [PRESC_W-1:0] presc,
   output logic               raw_q,
   output logic               expired,
   output logic [CNT_W-1:0]   eff_dt
);
   logic [CNT_W-1:0] product;
   logic [CNT_W-1:0] cnt_q;
   logic             edge_seen;

   assign product = CNT_W'(presc) * CNT_W'(dt_value);

   // P of 0 or 1 uses the count as programmed; larger P subtracts one
   always_comb begin
      if (presc <= PRESC_W'(1))
         eff_dt = CNT_W'(dt_value);
      else if (product == '0)
         eff_dt = '0;
      else
         eff_dt = product - CNT_W'(1);
   end

   assign edge_seen = (raw != raw_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         cnt_q <= '0;
      end else if (edge_seen) begin
         raw_q <= raw;
         cnt_q <= eff_dt;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!expired && !edge_seen) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R6
   AST_RESTART_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> (raw_q == $past(raw) && cnt_q == $past(eff_dt))); // R9
endmodule

// File: rtl/pwm_dt_outgen.sv
module pwm_dt_outgen (
   input  logic comp_mode,
   input  logic raw,
   input  logic raw_q,
   input  logic expired,
   output logic out_even,
   output logic out_odd
);
   logic even_ok, odd_ok;

   // an output is allowed only when the live level, the settled level and
   // the expired count all agree; a fresh edge therefore clears it at once
   assign even_ok =  raw &&  raw_q && expired;
   assign odd_ok  = !raw && !raw_q && expired;

   always_comb begin
      if (comp_mode) begin
         out_even = even_ok;
         out_odd  = odd_ok;
      end else begin
         out_even = raw;
         out_odd  = !raw;
      end
   end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
   import pwm_deadband_pkg::*;
#(
   parameter int                DT_W     = 12,
   parameter int                PRESC_W  = 3,
   parameter logic [DT_W-1:0]   DT_RESET = '1,
   localparam int               NLANES   = lanes_for(DT_W),
   localparam int               ADDR_W   = addr_bits_for(NLANES),
   localparam int               CNT_W    = DT_W + PRESC_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [7:0]         rd_data,
   input  logic               prot_set,
   input  logic [PRESC_W-1:0] presc,
   input  logic               comp_mode,
   input  logic               pwm_raw,
   output logic               out_even,
   output logic               out_odd
);
   generate
      if (DT_W < 1 || DT_W > 16) begin : g_bad_dt_w
         $error("pwm_deadband: DT_W must lie in 1..16");
      end
      if (PRESC_W < 1 || PRESC_W > 8) begin : g_bad_presc_w
         $error("pwm_deadband: PRESC_W must lie in 1..8");
      end
   endgenerate

   logic [DT_W-1:0]  dt_value;
   logic             locked;
   logic             raw_q;
   logic             expired;
   logic [CNT_W-1:0] eff_dt;

   pwm_dt_regfile #(
      .DT_W    (DT_W),
      .DT_RESET(DT_RESET),
      .NLANES  (NLANES),
      .ADDR_W  (ADDR_W)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .prot_set(prot_set),
      .dt_value(dt_value),
      .locked  (locked)
   );

   pwm_dt_timer #(
      .DT_W   (DT_W),
      .PRESC_W(PRESC_W),
      .CNT_W  (CNT_W)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (pwm_raw),
      .dt_value(dt_value),
      .presc   (presc),
      .raw_q   (raw_q),
      .expired (expired),
      .eff_dt  (eff_dt)
   );

   pwm_dt_outgen outgen_i (
      .comp_mode(comp_mode),
      .raw      (pwm_raw),
      .raw_q    (raw_q),
      .expired  (expired),
      .out_even (out_even),
      .out_odd  (out_odd)
   );

   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      comp_mode |-> !(out_even && out_odd)); // R8
   AST_OFF_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_mode && pwm_raw != raw_q) |-> (!out_even && !out_odd)); // R6
   AST_EFF_LOW_P: assert property (@(posedge clk) disable iff (!rst_n)
      (presc <= PRESC_W'(1)) |-> (eff_dt == CNT_W'(dt_value))); // R5
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(NLANES - 1)) |-> (rd_data >> (DT_W - (NLANES - 1) * 8)) == 8'h00); // R3
   AST_UNLOCKED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(prot_set)); // R4
endmodule

// File: tb/pwm_deadband_tb_top.sv
`timescale 1ns/1ps
module pwm_deadband_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       prot_set = 1'b0;
   logic [2:0] presc = 3'd1;
   logic       comp_mode = 1'b1;
   logic       pwm_raw = 1'b0;
   logic       out_even, out_odd;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   bit mon_en   = 1'b0;
   bit even_seen = 1'b0;
   int both_hits = 0;

   always #5 clk = ~clk;

   pwm_deadband dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .prot_set(prot_set), .presc(presc), .comp_mode(comp_mode),
      .pwm_raw(pwm_raw), .out_even(out_even), .out_odd(out_odd)
   );

   // {P, programmed value, expected edges}
   localparam logic [31:0] VEC [8] = '{
      {8'd1, 12'd5, 12'd5},
      {8'd2, 12'd5, 12'd9},
      {8'd3, 12'd4, 12'd11},
      {8'd0, 12'd3, 12'd3},
      {8'd2, 12'd0, 12'd0},
      {8'd1, 12'd0, 12'd0},
      {8'd4, 12'd1, 12'd3},
      {8'd7, 12'd2, 12'd13}
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   // drives pwm_raw at a negedge; returns the number of edges after the
   // sampling edge until the turning-on output rises
   task automatic drive_measure(input logic lvl, output int k);
      pwm_raw = lvl;
      #1;
      k = 0;
      for (int i = 0; i < 200; i++) begin
         @(posedge clk);
         @(negedge clk);
         if ((lvl && out_even) || (!lvl && out_odd)) break;
         k++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         if (both_hits != 0) n_fail++;
         n_checks++;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && comp_mode && out_even && out_odd) both_hits++;
      if (mon_en && out_even) even_seen = 1'b1;
   end

   initial begin
      #200000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, d); check("R1 low byte", d, 8'hFF);
      rd(1'b1, d); check("R1 high byte", d, 8'h0F);
      check("R1 odd active at rest", out_odd, 1);
      check("R1 even idle at rest", out_even, 0);

      // R2 / R3 byte writes
      wr(1'b0, 8'hA5);
      rd(1'b0, d); check("R2 low byte write", d, 8'hA5);
      rd(1'b1, d); check("R2 high byte kept", d, 8'h0F);
      wr(1'b1, 8'hF3);
      rd(1'b1, d); check("R3 reserved bits zero", d, 8'h03);
      rd(1'b0, d); check("R2 low byte kept", d, 8'hA5);

      // R5 R6 R7 vector table
      for (int v = 0; v < 8; v++) begin
         logic [7:0]  p;
         logic [11:0] n, e;
         {p, n, e} = VEC[v];
         wr(1'b0, n[7:0]);
         wr(1'b1, {4'h0, n[11:8]});
         presc = p[2:0];
         @(negedge clk);
         pwm_raw = 1'b1;
         #1 check("R6 odd off at once", out_odd, 0);
         pwm_raw = 1'b0;
         #1;
         drive_measure(1'b1, k);
         check($sformatf("R5 R6 rise delay v%0d", v), k, int'(e));
         @(negedge clk);
         pwm_raw = 1'b0;
         #1 check("R7 even off at once", out_even, 0);
         pwm_raw = 1'b1;
         #1;
         drive_measure(1'b0, k);
         check($sformatf("R5 R7 fall delay v%0d", v), k, int'(e));
      end

      // R9 restart on early toggle
      wr(1'b0, 8'd6); wr(1'b1, 8'd0);
      presc = 3'd1;
      @(negedge clk);
      even_seen = 1'b0; mon_en = 1'b1;
      pwm_raw = 1'b1;
      repeat (4) @(negedge clk);
      drive_measure(1'b0, k);
      mon_en = 1'b0;
      check("R9 pending even never rose", even_seen, 0);
      check("R9 full restart delay", k, 6);

      // R10 independent mode
      @(negedge clk);
      comp_mode = 1'b0;
      pwm_raw = 1'b1;
      #1 check("R10 even follows", out_even, 1);
      check("R10 odd inverse", out_odd, 0);
      pwm_raw = 1'b0;
      #1 check("R10 even follows low", out_even, 0);
      check("R10 odd inverse high", out_odd, 1);
      comp_mode = 1'b1;
      repeat (8) @(negedge clk);

      // R4 lock: write at the lock edge applies, later writes ignored
      @(negedge clk);
      prot_set = 1'b1; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h12;
      @(negedge clk);
      prot_set = 1'b0; wr_en = 1'b0;
      rd(1'b0, d); check("R4 same-edge write", d, 8'h12);
      wr(1'b0, 8'h34);
      rd(1'b0, d); check("R4 low write ignored", d, 8'h12);
      wr(1'b1, 8'h0C);
      rd(1'b1, d); check("R4 high write ignored", d, 8'h00);

      // R1 reset clears lock and value
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(1'b0, d); check("R1 low after reset", d, 8'hFF);
      rd(1'b1, d); check("R1 high after reset", d, 8'h0F);
      wr(1'b0, 8'h55);
      rd(1'b0, d); check("R1 R4 lock cleared by reset", d, 8'h55);

      // R8 never both high (monitor)
      finish_run();
   end
endmodule